// File: doc/BRIEF.md
# Integer ALU with Condition Codes

This block is the integer execution stage of a register-window RISC core. Each cycle it takes two 32-bit operands and an opcode and produces the result. The opcode selects an add or subtract, with or without the carry flag folded in, a tagged add with or without a trap, one of six bitwise operations, or a shift. When flag setting is enabled and the operation can set flags, the unit also writes new N, Z, V and C condition flags. A 13-bit immediate is sign-extended to 32 bits by the caller before it reaches the unit.

Tagged arithmetic treats the two low bits of each operand as a type tag. A nonzero tag on either side counts as overflow. The trapping variant raises a tag-overflow request and leaves the condition flags unchanged. All outputs come from registers, one cycle after the inputs are applied, and a synchronous active-high reset clears them.

Top module: `int_alu_cc`

## Requirements
- R1: While reset is held, and one cycle after it is asserted, `result`, `flags_out`, `flags_we` and `tag_trap` are all zero.
- R2: Opcode 0 (add) gives a+b, and opcode 1 gives a+b+C. With flags enabled, C is the unsigned carry out of bit 31 and V is signed overflow. Every output appears one clock after its inputs.
- R3: Opcode 2 (subtract) gives a-b, and opcode 3 gives a-b-C. With flags enabled, C is the unsigned borrow out of bit 31 and V is signed overflow.
- R4: Opcode 4 (tagged add) gives a+b. Its V flag is set on signed overflow and also when bits [1:0] of either operand are nonzero. C follows the add rule.
- R5: Opcode 5 (trapping tagged add) gives a+b. It raises `tag_trap` whenever its V would be set, whether or not flags are enabled. While `tag_trap` is raised, `flags_we` is low and `flags_out` equals the incoming flags. Otherwise it behaves like opcode 4.
- R6: Opcodes 6 to 11 are AND, ANDN (a & ~b), OR, ORN (a | ~b), XOR and XNOR (a ^ ~b). With flags enabled they write N and Z from the result and clear V and C.
- R7: Opcodes 12, 13 and 14 shift operand a left, logical right and arithmetic right by b[4:0]. The upper bits of b are ignored. Shifts never write flags, even with flags enabled.
- R8: When `set_cc` is low, `flags_we` is low and `flags_out` equals `flags_in` from the same input cycle.
- R9: On every flag write, N equals result bit 31, and Z is 1 exactly when all 32 result bits are zero.
- R10: Flag vectors are packed as {N,Z,V,C} in bits [3:0]. `flags_in` bit 0 is the carry used by opcodes 1 and 3.
- R11: Opcode 15 is unused. It gives a zero result, writes no flags and raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand or sign-extended immediate |
| opcode | input | 4 | Operation select |
| set_cc | input | 1 | Request to update the condition flags |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| result | output | 32 | Registered result |
| flags_out | output | 4 | New flags, or the incoming flags when no write happens |
| flags_we | output | 1 | Flags write strobe |
| tag_trap | output | 1 | Tag-overflow trap request |

## Verification
Two functions can land in the same cycle: the flag update and the tag-overflow trap. Both follow from one trapping tagged add issued with `set_cc` high. The bench provokes the collision with tagged operands and with clean operands that overflow. In those cycles it expects the trap, a low write strobe and the untouched incoming flags, and it expects a normal flag write when neither cause is present. The carry input meets overflow in the same way on add-with-carry and subtract-with-borrow near the signed limits. A behavioural model in the bench judges every cycle against its own arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBC  = 4'd3,
    OP_TADD  = 4'd4,
    OP_TADDT = 4'd5,
    OP_AND   = 4'd6,
    OP_ANDN  = 4'd7,
    OP_OR    = 4'd8,
    OP_ORN   = 4'd9,
    OP_XOR   = 4'd10,
    OP_XNOR  = 4'd11,
    OP_SLL   = 4'd12,
    OP_SRL   = 4'd13,
    OP_SRA   = 4'd14,
    OP_NONE  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } icc_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             ovf,
  output logic             cout
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             c_eff;
  logic             a_s, b_s, r_s;

  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    sum   = a + b_eff + {{(WIDTH-1){1'b0}}, c_eff};
    a_s   = a[MSB];
    b_s   = b[MSB];
    r_s   = sum[MSB];
    if (sub) begin
      ovf  = (a_s & ~b_s & ~r_s) | (~a_s & b_s & r_s);
      cout = (~a_s & b_s) | ((~a_s | b_s) & r_s);
    end else begin
      ovf  = (a_s & b_s & ~r_s) | (~a_s & ~b_s & r_s);
      cout = (a_s & b_s) | ((a_s | b_s) & ~r_s);
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       sel,
  output logic [WIDTH-1:0] y
);
  logic [WIDTH-1:0] bx;

  always_comb begin
    bx = sel[0] ? ~b : b;
    unique case (sel[2:1])
      2'd0:    y = a & bx;
      2'd1:    y = a | bx;
      2'd2:    y = a ^ bx;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SHW-1:0]   amt,
  input  logic [1:0]       kind,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (kind)
      2'd0:    y = a << amt;
      2'd1:    y = a >> amt;
      2'd2:    y = WIDTH'($signed(a) >>> amt);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc #(
  parameter int WIDTH = 32,
  parameter int TAGW  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       opcode,
  input  logic             set_cc,
  input  logic [3:0]       flags_in,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags_out,
  output logic             flags_we,
  output logic             tag_trap
);
  import alu_pkg::*;
  localparam int SHW = $clog2(WIDTH);

  alu_op_e          op;
  icc_t             fin, fnew, fnext;
  logic [WIDTH-1:0] as_sum, lg_y, sh_y, res_d;
  logic             as_ovf, as_cout, as_sub, as_cin;
  logic             is_arith, is_tag, is_logic, cc_ok, tag_bad, trap_d, we_d;
  logic [2:0]       lg_sel;
  logic [1:0]       sh_kind;

  assign op  = alu_op_e'(opcode);
  assign fin = icc_t'(flags_in);

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBC);
    is_tag   = (op == OP_TADD) || (op == OP_TADDT);
    is_logic = (opcode >= 4'd6) && (opcode <= 4'd11);
    as_sub   = (op == OP_SUB) || (op == OP_SUBC);
    as_cin   = ((op == OP_ADDC) || (op == OP_SUBC)) && fin.c;
    lg_sel   = 3'(opcode - 4'd6);
    sh_kind  = 2'(opcode - 4'd12);
    tag_bad  = (|op_a[TAGW-1:0]) | (|op_b[TAGW-1:0]);
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(op_a), .b(op_b), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .ovf(as_ovf), .cout(as_cout)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a(op_a), .b(op_b), .sel(lg_sel), .y(lg_y)
  );

  alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a(op_a), .amt(op_b[SHW-1:0]), .kind(sh_kind), .y(sh_y)
  );

  always_comb begin
    fnew  = '0;
    res_d = '0;
    if (is_arith || is_tag) begin
      res_d  = as_sum;
      fnew.v = as_ovf | (is_tag & tag_bad);
      fnew.c = as_cout;
    end else if (is_logic) begin
      res_d = lg_y;
    end else if (op != OP_NONE) begin
      res_d = sh_y;
    end
    fnew.n = res_d[WIDTH-1];
    fnew.z = (res_d == '0);
    cc_ok  = is_arith || is_tag || is_logic;
    trap_d = (op == OP_TADDT) && fnew.v;
    we_d   = set_cc && cc_ok && !trap_d;
    fnext  = we_d ? fnew : fin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flags_out <= '0;
      flags_we  <= 1'b0;
      tag_trap  <= 1'b0;
    end else begin
      result    <= res_d;
      flags_out <= fnext;
      flags_we  <= we_d;
      tag_trap  <= trap_d;
    end
  end

  // R8: disabled flag update passes the incoming flags through
  p_hold_flags_r8: assert property (@(posedge clk) disable iff (rst)
    !set_cc |=> (!flags_we && flags_out == $past(flags_in)));

  // R5: a raised trap blocks the write and keeps the old flags
  p_trap_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    tag_trap |-> (!flags_we && flags_out == $past(flags_in)));

  // R9: N and Z follow the registered result on every write
  p_nz_match_r9: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_out[3] == result[WIDTH-1] && flags_out[2] == (result == '0)));

  // R6: logic operations clear V and C
  p_logic_vc_r6: assert property (@(posedge clk) disable iff (rst)
    (set_cc && is_logic) |=> (flags_we && flags_out[1:0] == 2'b00));

  // R7: shifts never write the flags
  p_shift_nowe_r7: assert property (@(posedge clk) disable iff (rst)
    (opcode >= 4'd12 && opcode <= 4'd14) |=> !flags_we);

  // R11: unused opcode yields nothing
  p_unused_r11: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd15) |=> (result == '0 && !flags_we && !tag_trap));
endmodule

// File: tb/int_alu_cc_tb_top.sv
`timescale 1ns/1ps
module int_alu_cc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  opcode = '0;
  logic        set_cc = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [31:0] result;
  logic [3:0]  flags_out;
  logic        flags_we, tag_trap;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected values for the cycle in flight
  logic [31:0] e_res;
  logic [3:0]  e_flg;
  logic        e_we, e_trap;
  string       e_req;
  bit          pending = 0;

  always #2.5 clk = ~clk;

  int_alu_cc dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
    .set_cc(set_cc), .flags_in(flags_in), .result(result),
    .flags_out(flags_out), .flags_we(flags_we), .tag_trap(tag_trap)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural model; flags packed {N,Z,V,C} (R10)
  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                       input logic sc, input logic [3:0] fi);
    logic [32:0] w;
    logic [31:0] r;
    logic v, c, ok, tb;
    int sh;
    v = 0; c = 0; ok = 1; r = '0; sh = int'(b[4:0]);
    tb = (a[1:0] != 0) || (b[1:0] != 0);
    case (op)
      0, 1, 4, 5: begin
        w = {1'b0, a} + {1'b0, b} + ((op == 1) ? {32'd0, fi[0]} : 33'd0);
        r = w[31:0]; c = w[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
        if (op >= 4) v = v || tb;
        e_req = (op == 5) ? "R5" : (op == 4) ? "R4" : "R2";
      end
      2, 3: begin
        w = {1'b0, a} - {1'b0, b} - ((op == 3) ? {32'd0, fi[0]} : 33'd0);
        r = w[31:0]; c = w[32];
        v = (a[31] != b[31]) && (r[31] != a[31]);
        e_req = "R3";
      end
      6:  begin r = a & ~(~b); e_req = "R6"; end
      7:  begin r = a & ~b;    e_req = "R6"; end
      8:  begin r = a | b;     e_req = "R6"; end
      9:  begin r = a | ~b;    e_req = "R6"; end
      10: begin r = a ^ b;     e_req = "R6"; end
      11: begin r = ~(a ^ b);  e_req = "R6"; end
      12: begin r = a << sh; ok = 0; e_req = "R7"; end
      13: begin r = a >> sh; ok = 0; e_req = "R7"; end
      14: begin r = 32'($signed(a) >>> sh); ok = 0; e_req = "R7"; end
      default: begin r = '0; ok = 0; e_req = "R11"; end
    endcase
    e_res  = r;
    e_trap = (op == 5) && v;
    e_we   = sc && ok && !e_trap;
    e_flg  = e_we ? {r[31], (r == 0), v, c} : fi;
    if (!sc) e_req = {e_req, "/R8"};
    else if (e_we) e_req = {e_req, "/R9"};
    pending = 1;
  endtask

  task automatic compare();
    if (!pending) return;
    chk(e_req, "result", result, e_res);
    chk(e_req, "flags", {28'd0, flags_out}, {28'd0, e_flg});
    chk(e_req, "we", {31'd0, flags_we}, {31'd0, e_we});
    chk(e_req, "trap", {31'd0, tag_trap}, {31'd0, e_trap});
  endtask

  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                      input logic sc, input logic [3:0] fi);
    @(negedge clk);
    compare();
    op_a = a; op_b = b; opcode = op; set_cc = sc; flags_in = fi;
    model(a, b, op, sc, fi);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; opcode = 4'd5; set_cc = 1; flags_in = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "result", result, 32'd0);
    chk("R1", "flags", {28'd0, flags_out}, 32'd0);
    chk("R1", "we", {31'd0, flags_we}, 32'd0);
    chk("R1", "trap", {31'd0, tag_trap}, 32'd0);
    rst = 0;
    // R2: overflow, carry/zero, carry-in with overflow
    step(32'h7FFF_FFFF, 32'h1, 0, 1, 4'h0);
    step(32'hFFFF_FFFF, 32'h1, 0, 1, 4'h0);
    step(32'h7FFF_FFFE, 32'h1, 1, 1, 4'h1);
    step(32'hFFFF_FFFF, 32'h0, 1, 1, 4'h1);
    // R3: borrow, sub-with-borrow into overflow
    step(32'h0, 32'h1, 2, 1, 4'h0);
    step(32'h8000_0000, 32'h0, 3, 1, 4'h1);
    step(32'h5, 32'h5, 2, 1, 4'h0);
    // R4: tag bits and clean add
    step(32'h4, 32'h1, 4, 1, 4'h0);
    step(32'h4, 32'h8, 4, 1, 4'h0);
    step(32'h7FFF_FFFC, 32'h4, 4, 1, 4'h0);
    // R5: trap meets flag update in the same cycle
    step(32'h4, 32'h2, 5, 1, 4'hA);
    step(32'h7FFF_FFFC, 32'h4, 5, 1, 4'h5);
    step(32'h4, 32'h8, 5, 1, 4'h3);
    step(32'h1, 32'h0, 5, 0, 4'h6);
    // R6: logic ops with flags
    step(32'hF0F0_0000, 32'h0F0F_0000, 6, 1, 4'h3);
    step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 7, 1, 4'h3);
    step(32'h0, 32'h0, 9, 1, 4'h3);
    step(32'h1234_5678, 32'h1234_5678, 11, 1, 4'h0);
    // R7: shift amount masked to 5 bits, no flag write
    step(32'h1, 32'h21, 12, 1, 4'h9);
    step(32'h8000_0000, 32'hFFFF_FFFF, 13, 1, 4'h9);
    step(32'h8000_0000, 32'h1F, 14, 1, 4'h9);
    // R8 / R11
    step(32'h7FFF_FFFF, 32'h1, 0, 0, 4'hC);
    step(32'hDEAD_BEEF, 32'h1, 15, 1, 4'h7);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 4 == 0) begin a[1:0] = 0; b[1:0] = 0; end
      if (i % 7 == 0) a = {a[31], {31{~a[31]}}};
      if (i % 11 == 0) b = 32'(i % 40);
      step(a, b, 4'($urandom), 1'($urandom), 4'($urandom));
    end
    @(negedge clk);
    compare();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule